// File: doc/BRIEF.md
# Bus-Master Storage DMA Channel

This block is one channel of a bus-master DMA engine for a disk-style storage port. Software sees an eight-byte register window on a byte-wide bus. Through this window it sets a table pointer, picks a direction and sets a start flag. It then reads a status byte that reports progress and the outcome of the transfer. The engine fetches descriptors from memory. Each descriptor is two 32-bit words: a buffer address, and a word holding a byte count and an end-of-table flag. For each descriptor the engine moves data between a valid/ready device stream and a word-wide memory port.

The engine reports completion, a bus fault or a device interrupt by setting an interrupt flag, and that flag drives the `irq` output. Software clears the interrupt and error flags by writing ones to them. A transfer counts as clean only when the three low status bits read 100b.

Top module: `bmdma_channel`

## Requirements
- R1: After reset every offset of the register window reads 0x00 and `irq` is low.
- R2: Offset 0 holds the start flag at bit 0 and the direction at bit 3, and both read back. Offsets 1 and 3 always read 0x00. Offsets 4 to 7 hold the 32-bit table pointer, least significant byte at offset 4, and pointer bits [1:0] always read 0.
- R3: Status byte (offset 2) bits: 0 engine active, 1 error, 2 interrupt, and bits 5 and 6 are plain read/write capability flags for drive 0 and drive 1 (bit 5+unit).
- R4: Writing 1 to status bit 1 or bit 2 clears that bit, and writing 0 there leaves it unchanged. Writing back the value read ORed with 0x06 clears both.
- R5: A 0-to-1 write of the start flag makes the engine active and starts a descriptor walk at the pointer. Descriptor word 0 is the buffer address. Word 1 bits [15:0] are the byte count (0 means 65536), rounded up to whole 4-byte words, and word 1 bit 31 marks the last descriptor. Descriptors are 8 bytes apart and are processed in order.
- R6: With direction 1, words taken from the device input stream are written to memory at consecutive addresses. With direction 0, memory words are read in address order and offered on the device output stream.
- R7: After the last word of the end-of-table descriptor, active clears and interrupt sets in the same cycle, the low status bits read 100b and `irq` is high.
- R8: A memory response with the error flag sets the error bit and the interrupt bit and clears active, so the low bits read 110b. The faulting write does not land.
- R9: A device interrupt sets the interrupt bit. If it arrives mid-transfer, active stays set (low bits 101b) and the transfer still completes.
- R10: Writing the start flag from 1 to 0 stops the engine: active clears, no further memory requests are issued, and the interrupt bit is not set by the stop.
- R11: The device input stream is not accepted while the engine is idle, so data offered before start is held and becomes the first word written after start.
- R12: When a hardware event sets the interrupt bit in the same cycle that software writes 1 to clear it, the bit ends up set.
- R13: A direction change written while the engine is active is ignored, while the start flag in the same write still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | WIN_AW | Byte offset in the register window |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_err | input | 1 | Completing access ended in a bus error |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| din_valid | input | 1 | Device-to-memory word offered |
| din_data | input | DATA_W | Device-to-memory word |
| din_ready | output | 1 | Engine accepts the offered device word |
| dout_valid | output | 1 | Memory-to-device word offered |
| dout_data | output | DATA_W | Memory-to-device word |
| dout_ready | input | 1 | Device accepts the offered word |
| dev_irq | input | 1 | Device interrupt event |
| irq | output | 1 | Interrupt request, follows status bit 2 |

## Verification
The interrupt bit has two writers: the hardware set path (completion, bus error or device interrupt) and the software write-one-to-clear path. Both can act in the same clock. The bench provokes this by raising `dev_irq` in the same cycle as a status write of 0x04, then reads the status byte and expects bit 2 still set. A later write with no event in that cycle must clear the bit. The same overlap happens naturally when a completion lands while software is clearing an older interrupt, and the ordering inside the status update decides the result.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    // register window offsets
    localparam int OFS_CMD  = 0;
    localparam int OFS_STAT = 2;
    localparam int OFS_PTR  = 4;

    // command bits
    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;

    // status bits
    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_INT  = 2;
    localparam int ST_CAP0 = 5;

    typedef enum logic [2:0] {
        W_IDLE,
        W_DESC_A,
        W_DESC_B,
        W_DIN,
        W_MWR,
        W_MRD,
        W_DOUT
    } walk_st_e;

endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WIN_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIN_AW-1:0] rb_addr,
    input  logic              rb_wr,
    input  logic [7:0]        rb_wdata,
    output logic [7:0]        rb_rdata,
    input  logic              eng_busy,
    input  logic              eng_ok,
    input  logic              eng_fail,
    input  logic              dev_irq,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              dir_to_mem,
    output logic [ADDR_W-1:0] tbl_base,
    output logic              intr_flag,
    output logic              err_flag
);

    localparam int PTR_BYTES = ADDR_W / 8;

    typedef struct packed {
        logic              start;
        logic              dir;
        logic [1:0]        cap;
        logic              intr;
        logic              err;
        logic [ADDR_W-1:0] ptr;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_cmd, wr_stat;

    always_comb begin
        r_d     = r_q;
        wr_cmd  = rb_wr && (rb_addr == WIN_AW'(OFS_CMD));
        wr_stat = rb_wr && (rb_addr == WIN_AW'(OFS_STAT));

        if (wr_cmd) begin
            r_d.start = rb_wdata[CMD_GO];
            if (!eng_busy) r_d.dir = rb_wdata[CMD_DIR];
        end

        // software clear first, hardware set afterwards: a set wins
        if (wr_stat) begin
            if (rb_wdata[ST_ERR]) r_d.err  = 1'b0;
            if (rb_wdata[ST_INT]) r_d.intr = 1'b0;
            r_d.cap = rb_wdata[ST_CAP0 +: 2];
        end

        for (int b = 0; b < PTR_BYTES; b++) begin
            if (rb_wr && (rb_addr == WIN_AW'(OFS_PTR + b)))
                r_d.ptr[8*b +: 8] = rb_wdata;
        end
        r_d.ptr[1:0] = 2'b00;

        if (eng_ok || eng_fail || dev_irq) r_d.intr = 1'b1;
        if (eng_fail)                      r_d.err  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rb_rdata = 8'h00;
        if (rb_addr == WIN_AW'(OFS_CMD)) begin
            rb_rdata[CMD_GO]  = r_q.start;
            rb_rdata[CMD_DIR] = r_q.dir;
        end
        if (rb_addr == WIN_AW'(OFS_STAT)) begin
            rb_rdata[ST_ACT]        = eng_busy;
            rb_rdata[ST_ERR]        = r_q.err;
            rb_rdata[ST_INT]        = r_q.intr;
            rb_rdata[ST_CAP0 +: 2]  = r_q.cap;
        end
        for (int b = 0; b < PTR_BYTES; b++) begin
            if (rb_addr == WIN_AW'(OFS_PTR + b))
                rb_rdata = r_q.ptr[8*b +: 8];
        end
    end

    assign start_pulse = wr_cmd &&  rb_wdata[CMD_GO] && !r_q.start;
    assign stop_pulse  = wr_cmd && !rb_wdata[CMD_GO] &&  r_q.start;
    assign dir_to_mem  = r_q.dir;
    assign tbl_base    = r_q.ptr;
    assign intr_flag   = r_q.intr;
    assign err_flag    = r_q.err;

endmodule

// File: rtl/bmdma_walker.sv
module bmdma_walker
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pulse,
    input  logic              stop_pulse,
    input  logic              dir_to_mem,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              din_valid,
    input  logic [DATA_W-1:0] din_data,
    output logic              din_ready,
    output logic              dout_valid,
    output logic [DATA_W-1:0] dout_data,
    input  logic              dout_ready,
    output logic              busy,
    output logic              done_ok,
    output logic              done_fail
);

    localparam int WORD_B = DATA_W / 8;
    localparam int DESC_B = 2 * WORD_B;
    localparam int LEFT_W = CNT_W + 1;

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] addr;
        logic [LEFT_W-1:0] left;
        logic              last;
        logic [DATA_W-1:0] data;
    } walk_t;

    walk_t s_d, s_q;
    logic  step, fail;

    always_comb begin
        s_d        = s_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = s_q.addr;
        mem_wdata  = s_q.data;
        din_ready  = 1'b0;
        dout_valid = 1'b0;
        done_ok    = 1'b0;
        done_fail  = 1'b0;
        step       = 1'b0;
        fail       = 1'b0;

        case (s_q.st)
            W_IDLE: begin
                if (start_pulse) begin
                    s_d.cur = tbl_base;
                    s_d.st  = W_DESC_A;
                end
            end
            W_DESC_A: begin
                mem_req  = 1'b1;
                mem_addr = s_q.cur;
                if (mem_ack) begin
                    if (mem_err) fail = 1'b1;
                    else begin
                        s_d.addr = ADDR_W'(mem_rdata) & ~ADDR_W'(WORD_B - 1);
                        s_d.st   = W_DESC_B;
                    end
                end
            end
            W_DESC_B: begin
                mem_req  = 1'b1;
                mem_addr = s_q.cur + ADDR_W'(WORD_B);
                if (mem_ack) begin
                    if (mem_err) fail = 1'b1;
                    else begin
                        s_d.left = (mem_rdata[CNT_W-1:0] == '0) ?
                                   {1'b1, {CNT_W{1'b0}}} :
                                   {1'b0, mem_rdata[CNT_W-1:0]};
                        s_d.last = mem_rdata[DATA_W-1];
                        s_d.cur  = s_q.cur + ADDR_W'(DESC_B);
                        s_d.st   = dir_to_mem ? W_DIN : W_MRD;
                    end
                end
            end
            W_DIN: begin
                din_ready = 1'b1;
                if (din_valid) begin
                    s_d.data = din_data;
                    s_d.st   = W_MWR;
                end
            end
            W_MWR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    if (mem_err) fail = 1'b1;
                    else         step = 1'b1;
                end
            end
            W_MRD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    if (mem_err) fail = 1'b1;
                    else begin
                        s_d.data = mem_rdata;
                        s_d.st   = W_DOUT;
                    end
                end
            end
            W_DOUT: begin
                dout_valid = 1'b1;
                if (dout_ready) step = 1'b1;
            end
            default: s_d.st = W_IDLE;
        endcase

        if (step) begin
            s_d.addr = s_q.addr + ADDR_W'(WORD_B);
            if (s_q.left <= LEFT_W'(WORD_B)) begin
                if (s_q.last) begin
                    done_ok = 1'b1;
                    s_d.st  = W_IDLE;
                end else begin
                    s_d.st  = W_DESC_A;
                end
            end else begin
                s_d.left = s_q.left - LEFT_W'(WORD_B);
                s_d.st   = dir_to_mem ? W_DIN : W_MRD;
            end
        end

        if (fail) begin
            done_fail = 1'b1;
            s_d.st    = W_IDLE;
        end

        if (stop_pulse) begin
            done_ok   = 1'b0;
            done_fail = 1'b0;
            s_d.st    = W_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != W_IDLE);
    assign dout_data = s_q.data;

endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int WIN_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIN_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              din_valid,
    input  logic [DATA_W-1:0] din_data,
    output logic              din_ready,
    output logic              dout_valid,
    output logic [DATA_W-1:0] dout_data,
    input  logic              dout_ready,
    input  logic              dev_irq,
    output logic              irq
);

    logic              start_pulse, stop_pulse, dir_to_mem;
    logic [ADDR_W-1:0] tbl_base;
    logic              eng_busy, done_ok, done_fail;
    logic              intr_flag, err_flag;

    bmdma_regs #(
        .ADDR_W (ADDR_W),
        .WIN_AW (WIN_AW)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rb_addr     (reg_addr),
        .rb_wr       (reg_wr),
        .rb_wdata    (reg_wdata),
        .rb_rdata    (reg_rdata),
        .eng_busy    (eng_busy),
        .eng_ok      (done_ok),
        .eng_fail    (done_fail),
        .dev_irq     (dev_irq),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .dir_to_mem  (dir_to_mem),
        .tbl_base    (tbl_base),
        .intr_flag   (intr_flag),
        .err_flag    (err_flag)
    );

    bmdma_walker #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .dir_to_mem  (dir_to_mem),
        .tbl_base    (tbl_base),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_err     (mem_err),
        .mem_rdata   (mem_rdata),
        .din_valid   (din_valid),
        .din_data    (din_data),
        .din_ready   (din_ready),
        .dout_valid  (dout_valid),
        .dout_data   (dout_data),
        .dout_ready  (dout_ready),
        .busy        (eng_busy),
        .done_ok     (done_ok),
        .done_fail   (done_fail)
    );

    assign irq = intr_flag;

endmodule

// File: rtl/bmdma_channel_chk.sv
module bmdma_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_req,
    input logic mem_ack,
    input logic mem_err,
    input logic din_ready,
    input logic dout_valid,
    input logic dev_irq,
    input logic active,
    input logic intr_flag,
    input logic err_flag,
    input logic done_ok,
    input logic stop_pulse
);

    // R10: an idle engine touches neither memory nor the device streams
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!mem_req && !dout_valid));

    // R11: device input never accepted while idle
    p_idle_no_pull_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !din_ready);

    // R6: only one side of the data path is open at a time
    p_one_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, din_ready, dout_valid}));

    // R7: a clean finish leaves interrupt set and engine idle
    p_done_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |=> (intr_flag && !active));

    // R8: a bus error stops the engine and flags error plus interrupt
    p_bus_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err && !stop_pulse) |=> (!active && err_flag && intr_flag));

    // R8: error never rises without the interrupt bit
    p_err_with_intr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> intr_flag);

    // R9 / R12: a device interrupt always leaves the interrupt bit set
    p_devirq_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq |=> intr_flag);

endmodule

bind bmdma_channel bmdma_channel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .din_ready  (din_ready),
    .dout_valid (dout_valid),
    .dev_irq    (dev_irq),
    .active     (eng_busy),
    .intr_flag  (intr_flag),
    .err_flag   (err_flag),
    .done_ok    (done_ok),
    .stop_pulse (stop_pulse)
);

// File: tb/bmdma_channel_test.sv
module bmdma_channel_test;

    localparam int CLK_PERIOD = 10;
    localparam int TBL        = 32'h100;

    logic        clk, rst_n;
    logic [2:0]  reg_addr;
    logic        reg_wr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        din_valid, din_ready, dout_valid, dout_ready;
    logic [31:0] din_data, dout_data;
    logic        dev_irq, irq;

    bmdma_channel uut (
        .clk (clk), .rst_n (rst_n),
        .reg_addr (reg_addr), .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_ack (mem_ack), .mem_err (mem_err), .mem_rdata (mem_rdata),
        .din_valid (din_valid), .din_data (din_data), .din_ready (din_ready),
        .dout_valid (dout_valid), .dout_data (dout_data), .dout_ready (dout_ready),
        .dev_irq (dev_irq), .irq (irq)
    );

    logic [31:0] mem [0:4095];
    logic [31:0] din_q [0:63];
    logic [31:0] dout_got [0:63];
    logic [31:0] exp_w [0:63];
    logic [11:0] exp_a [0:63];
    int          d_cnt [0:3];
    logic [31:0] d_buf [0:3];
    int          din_n, din_i, dout_cnt, req_cycles;
    logic        din_take;
    bit          lat_rand, dout_rand, err_arm;
    logic [31:0] err_addr;
    int          total, bad;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int words_of(input int c);
        return (c == 0) ? 16384 : (c + 3) / 4;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_ptr(input logic [31:0] p);
        for (int b = 0; b < 4; b++) wr(3'(4 + b), p[8*b +: 8]);
    endtask

    task automatic wait_done(input int limit, output logic [7:0] s);
        int n;
        n = 0;
        do begin
            rd(3'd2, s);
            n++;
        end while (s[0] && n < limit);
    endtask

    // memory responder
    initial begin
        logic [11:0] idx;
        mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0; req_cycles = 0;
        forever begin
            @(negedge clk);
            if (mem_req) req_cycles++;
            if (mem_ack) begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end else if (mem_req && (!lat_rand || $urandom_range(0, 1) == 0)) begin
                idx     = mem_addr[13:2];
                mem_ack = 1'b1;
                if (err_arm && mem_addr == err_addr) mem_err = 1'b1;
                else if (mem_we) mem[idx] = mem_wdata;
                mem_rdata = mem[idx];
            end
        end
    end

    // device input producer
    initial begin
        din_valid = 1'b0; din_data = '0; din_take = 1'b0;
        forever begin
            @(negedge clk);
            if (din_take) din_i++;
            din_valid = (din_i < din_n);
            din_data  = (din_i < din_n) ? din_q[din_i] : 32'h0;
            din_take  = din_valid && din_ready;
        end
    end

    // device output consumer
    initial begin
        dout_ready = 1'b0;
        forever begin
            @(negedge clk);
            dout_ready = dout_rand ? ($urandom_range(0, 2) != 0) : 1'b1;
            if (dout_valid && dout_ready) begin
                if (dout_cnt < 64) dout_got[dout_cnt] = dout_data;
                dout_cnt++;
            end
        end
    end

    // descriptor run with expected-value model (R5, R6, R7)
    task automatic run_xfer(input bit to_mem, input int nd, input string req);
        int          nw;
        logic [11:0] idx;
        logic [7:0]  s;
        nw = 0;
        for (int i = 0; i < nd; i++) begin
            mem[TBL/4 + 2*i]     = d_buf[i];
            mem[TBL/4 + 2*i + 1] = {(i == nd - 1), 15'd0, 16'(d_cnt[i])};
            for (int j = 0; j < words_of(d_cnt[i]); j++) begin
                idx = 12'(d_buf[i][13:2] + j);
                if (to_mem) begin
                    din_q[nw] = $urandom;
                    mem[idx]  = 32'hDEAD_0000 | 32'(nw);
                    exp_w[nw] = din_q[nw];
                end else begin
                    exp_w[nw] = mem[idx];
                end
                exp_a[nw] = idx;
                nw++;
            end
        end
        din_i = 0; din_n = to_mem ? nw : 0; dout_cnt = 0;
        set_ptr(TBL);
        wr(3'd0, {4'b0, to_mem, 3'b000});
        wr(3'd0, {4'b0, to_mem, 3'b001});
        wait_done(5000, s);
        chk(req, "R7 status after finish", {24'h0, s}, 32'h04);
        chk(req, "R7 irq after finish", {31'h0, irq}, 32'h1);
        if (to_mem) begin
            for (int k = 0; k < nw; k++) chk(req, "R6 memory word", mem[exp_a[k]], exp_w[k]);
        end else begin
            chk(req, "R5 word count", 32'(dout_cnt), 32'(nw));
            for (int k = 0; k < nw; k++) chk(req, "R6 output word", dout_got[k], exp_w[k]);
        end
        wr(3'd2, s | 8'h06);
        wr(3'd0, {4'b0, to_mem, 3'b000});
    endtask

    initial begin
        logic [7:0] s;
        total = 0; bad = 0;
        void'($urandom(32'd5150));
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; dev_irq = 1'b0;
        din_n = 0; din_i = 0; dout_cnt = 0;
        lat_rand = 1'b1; dout_rand = 1'b1; err_arm = 1'b0; err_addr = '0;
        for (int i = 0; i < 4096; i++) mem[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), s);
            chk("R1", "reset readback", {24'h0, s}, 32'h0);
        end
        chk("R1", "reset irq", {31'h0, irq}, 32'h0);

        // R2 register map
        wr(3'd0, 8'h08); rd(3'd0, s); chk("R2", "command readback", {24'h0, s}, 32'h08);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'hFF); rd(3'd1, s); chk("R2", "spare 1", {24'h0, s}, 32'h0);
        wr(3'd3, 8'hFF); rd(3'd3, s); chk("R2", "spare 3", {24'h0, s}, 32'h0);
        set_ptr(32'h1234_567B);
        rd(3'd4, s); chk("R2", "ptr byte0", {24'h0, s}, 32'h78);
        rd(3'd7, s); chk("R2", "ptr byte3", {24'h0, s}, 32'h12);

        // R3 capability flags
        wr(3'd2, 8'h60); rd(3'd2, s); chk("R3", "both caps", {24'h0, s}, 32'h60);
        wr(3'd2, 8'h20); rd(3'd2, s); chk("R3", "drive0 cap", {24'h0, s}, 32'h20);
        wr(3'd2, 8'h00); rd(3'd2, s); chk("R3", "caps cleared", {24'h0, s}, 32'h00);

        // R5 R6 R7 directed memory-to-device, two descriptors
        d_buf[0] = 32'h2000; d_cnt[0] = 12;
        d_buf[1] = 32'h2400; d_cnt[1] = 8;
        run_xfer(1'b0, 2, "R5");

        // R4 zero writes keep, OR 0x06 clears
        d_buf[0] = 32'h2800; d_cnt[0] = 4;
        mem[TBL/4] = d_buf[0]; mem[TBL/4 + 1] = 32'h8000_0004;
        set_ptr(TBL); wr(3'd0, 8'h00); wr(3'd0, 8'h01);
        wait_done(5000, s);
        wr(3'd2, 8'h00); rd(3'd2, s); chk("R4", "write zero keeps intr", {24'h0, s}, 32'h04);
        wr(3'd2, s | 8'h06); rd(3'd2, s); chk("R4", "or 0x06 clears", {24'h0, s}, 32'h00);
        wr(3'd0, 8'h00);

        // R11 data offered before start is held
        d_buf[0] = 32'h3000; d_cnt[0] = 6;
        mem[TBL/4] = d_buf[0]; mem[TBL/4 + 1] = 32'h8000_0006;
        din_q[0] = 32'hCAFE_0001; din_q[1] = 32'hCAFE_0002; mem[12'hC00] = '0; mem[12'hC01] = '0;
        din_i = 0; din_n = 2;
        set_ptr(TBL); wr(3'd0, 8'h08);
        repeat (3) @(negedge clk);
        #1;
        chk("R11", "ready low while idle", {31'h0, din_ready}, 32'h0);
        chk("R11", "data still offered", {31'h0, din_valid}, 32'h1);
        wr(3'd0, 8'h09);
        wait_done(5000, s);
        chk("R11", "status", {24'h0, s}, 32'h04);
        chk("R11", "first word", mem[12'hC00], 32'hCAFE_0001);
        chk("R5", "rounded count second word", mem[12'hC01], 32'hCAFE_0002);
        wr(3'd2, 8'h06); wr(3'd0, 8'h08);

        // R9 and R13: engine waiting on device data
        d_buf[0] = 32'h3800; d_cnt[0] = 8;
        mem[TBL/4] = d_buf[0]; mem[TBL/4 + 1] = 32'h8000_0008;
        din_i = 0; din_n = 0;
        set_ptr(TBL); wr(3'd0, 8'h08); wr(3'd0, 8'h09);
        repeat (6) @(negedge clk);
        rd(3'd2, s); chk("R9", "busy before irq", {24'h0, s}, 32'h01);
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); dev_irq = 1'b0;
        rd(3'd2, s); chk("R9", "active plus intr", {24'h0, s}, 32'h05);
        wr(3'd0, 8'h01); rd(3'd0, s); chk("R13", "dir held while active", {24'h0, s}, 32'h09);
        din_q[0] = 32'hBEEF_0010; din_q[1] = 32'hBEEF_0011; din_i = 0; din_n = 2;
        wait_done(5000, s);
        chk("R9", "finished after irq", {24'h0, s}, 32'h04);
        chk("R9", "data landed", mem[12'hE01], 32'hBEEF_0011);
        wr(3'd2, 8'h06); wr(3'd0, 8'h08);

        // R8 bus error on third write
        d_buf[0] = 32'h3400; d_cnt[0] = 16;
        mem[TBL/4] = d_buf[0]; mem[TBL/4 + 1] = 32'h8000_0010;
        mem[12'hD02] = 32'h1111_2222;
        for (int i = 0; i < 4; i++) din_q[i] = 32'hA0A0_0000 | 32'(i);
        din_i = 0; din_n = 4; err_arm = 1'b1; err_addr = 32'h3408;
        set_ptr(TBL); wr(3'd0, 8'h08); wr(3'd0, 8'h09);
        wait_done(5000, s);
        chk("R8", "status after bus error", {24'h0, s}, 32'h06);
        chk("R8", "irq after bus error", {31'h0, irq}, 32'h1);
        chk("R8", "earlier word written", mem[12'hD01], 32'hA0A0_0001);
        chk("R8", "faulting word not written", mem[12'hD02], 32'h1111_2222);
        err_arm = 1'b0; din_n = 0;
        wr(3'd2, s | 8'h06); rd(3'd2, s); chk("R4", "error cleared", {24'h0, s}, 32'h00);
        wr(3'd0, 8'h00);

        // R12 set and clear in the same cycle
        @(negedge clk);
        dev_irq = 1'b1; reg_addr = 3'd2; reg_wr = 1'b1; reg_wdata = 8'h04;
        @(negedge clk);
        dev_irq = 1'b0; reg_wr = 1'b0;
        rd(3'd2, s); chk("R12", "set wins", {24'h0, s}, 32'h04);
        wr(3'd2, 8'h04); rd(3'd2, s); chk("R12", "later clear", {24'h0, s}, 32'h00);

        // R10 stop mid-transfer
        mem[TBL/4] = 32'h1000; mem[TBL/4 + 1] = 32'h8000_0000;
        set_ptr(TBL); wr(3'd0, 8'h00); wr(3'd0, 8'h01);
        repeat (40) @(negedge clk);
        wr(3'd0, 8'h00);
        rd(3'd2, s); chk("R10", "stopped status", {24'h0, s}, 32'h00);
        req_cycles = 0;
        repeat (20) @(negedge clk);
        chk("R10", "no requests after stop", 32'(req_cycles), 32'h0);

        // random descriptor chains
        for (int r = 0; r < 8; r++) begin
            int  nd;
            bit  dir;
            nd  = $urandom_range(1, 3);
            dir = 1'($urandom_range(0, 1));
            for (int i = 0; i < nd; i++) begin
                d_buf[i] = 32'h2000 + 32'(i) * 32'h100 + 32'($urandom_range(0, 15)) * 4;
                d_cnt[i] = $urandom_range(1, 24);
            end
            run_xfer(dir, nd, "R6");
        end

        // R5 zero count means 64 KiB
        lat_rand = 1'b0; dout_rand = 1'b0;
        mem[TBL/4] = 32'h0; mem[TBL/4 + 1] = 32'h8000_0000;
        dout_cnt = 0;
        set_ptr(TBL); wr(3'd0, 8'h00); wr(3'd0, 8'h01);
        wait_done(60000, s);
        chk("R5", "64K status", {24'h0, s}, 32'h04);
        chk("R5", "64K word count", 32'(dout_cnt), 32'd16384);
        chk("R5", "64K first word", dout_got[0], mem[0]);
        chk("R5", "64K word 5", dout_got[5], mem[5]);
        wr(3'd2, 8'h06); wr(3'd0, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule